// File: doc/BRIEF.md
# Programmable AND-OR Logic Array

This block is a configurable sum-of-products engine. A bank of product terms, each fed with the true and the inverted copy of every primary input, drives a set of output OR gates. Both connection matrices can be rewritten. The AND matrix chooses which literals each term takes. The OR matrix chooses which terms each output collects. Because the OR matrix is programmable, one product term can feed any number of outputs.

Links are stored as one bit each: 1 means the link is intact and 0 means it is broken. A broken AND link makes that literal a constant 1, so the input no longer affects the term. A broken OR link makes that term add nothing to the output. The erased state has every link intact. In that state each term holds both polarities of every input, so every term and every output is 0.

Configuration is loaded one term row at a time through a write port. An erase input wipes the whole array in one clock. Each clock the link store decodes one of three operations:
- `CFG_HOLD`: nothing changes.
- `CFG_LOAD`: one row is written.
- `CFG_WIPE`: every link returns to intact.

The transition rules are:
- erase high selects `CFG_WIPE`, whatever the write enable is.
- write enable high with erase low selects `CFG_LOAD`.
- otherwise the store is in `CFG_HOLD`.

The path from inputs to outputs has no registers.

Top module: `sop_array`

## Requirements
- R1: After reset every link is intact, so every output is 0 for every input pattern.
- R2: A product term is the AND of its intact literals only. AND-row bit 2i marks the true literal of input i as intact, and bit 2i+1 marks its inverted literal as intact. A literal whose bit is 0 acts as 1.
- R3: A term that keeps both the true and the inverted literal of any one input evaluates to 0.
- R4: A term whose AND bits are all 0 evaluates to 1 for every input pattern.
- R5: OR-row bit j connects the term to output j. A term whose OR row has several bits set drives all of those outputs.
- R6: A term with a broken OR link adds nothing to that output. An output with no intact link from any true term reads 0.
- R7: With write enable high and erase low, the row at the given address takes the AND and OR data at the clock edge. Outputs reflect it right after that edge, and other rows keep their contents.
- R8: With erase high, every AND and OR link is intact after the next clock edge, so all outputs read 0.
- R9: When erase and write enable are both high in the same cycle, the erase wins and the written data is discarded.
- R10: With write enable and erase both low, the data on the configuration port has no effect on the array.
- R11: Outputs follow input changes combinationally, with no clock in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset to the erased state |
| erase | input | 1 | Synchronous wipe of every link to intact |
| cfg_we | input | 1 | Row write enable |
| cfg_addr | input | ADDR_W | Index of the product-term row being written |
| cfg_and | input | 2*N_IN | AND links for the row: bit 2i is the true literal of input i, bit 2i+1 its inverse |
| cfg_or | input | N_OUT | OR links for the row: bit j connects the term to output j |
| in_vec | input | N_IN | Primary inputs |
| out_vec | output | N_OUT | Sum-of-products outputs |

## Verification
The two configuration operations that can fall in the same cycle are the row load and the full wipe. The bench first loads a row that drives every output high and confirms it. It then raises erase together with a write of another all-ones row at a different address. An independent model of the array is kept in the bench, and erase priority is judged by sweeping all input patterns afterwards and expecting all-zero outputs. A write with the enable low is judged the same way, against an unchanged model.

// File: rtl/sop_array_pkg.sv
package sop_array_pkg;

    typedef enum logic [1:0] {
        CFG_HOLD = 2'd0,
        CFG_LOAD = 2'd1,
        CFG_WIPE = 2'd2
    } cfg_op_e;

    function automatic cfg_op_e pick_op(input logic wipe, input logic load);
        if (wipe)      return CFG_WIPE;
        else if (load) return CFG_LOAD;
        else           return CFG_HOLD;
    endfunction

endpackage

// File: rtl/sop_link_store.sv
module sop_link_store
    import sop_array_pkg::*;
#(
    parameter int N_IN   = 8,
    parameter int N_OUT  = 4,
    parameter int N_TERM = 16,
    localparam int LIT_W  = 2 * N_IN,
    localparam int ADDR_W = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              erase,
    input  logic                              cfg_we,
    input  logic [ADDR_W-1:0]                 cfg_addr,
    input  logic [LIT_W-1:0]                  cfg_and,
    input  logic [N_OUT-1:0]                  cfg_or,
    output logic [N_TERM-1:0][LIT_W-1:0]      and_map,
    output logic [N_TERM-1:0][N_OUT-1:0]      or_map
);

    cfg_op_e op;
    logic    addr_ok;

    always_comb begin
        op      = pick_op(erase, cfg_we);
        addr_ok = int'(cfg_addr) < N_TERM;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            and_map <= '1;
            or_map  <= '1;
        end else begin
            unique case (op)
                CFG_WIPE: begin
                    and_map <= '1;
                    or_map  <= '1;
                end
                CFG_LOAD: begin
                    if (addr_ok) begin
                        and_map[cfg_addr] <= cfg_and;
                        or_map[cfg_addr]  <= cfg_or;
                    end
                end
                CFG_HOLD: ;
                default: ;
            endcase
        end
    end

    // R8: a wipe leaves every link intact one edge later
    a_r8_wipe_all: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> (&and_map) && (&or_map));

    // R9: with both requests high, the addressed row holds all-intact, not the data
    a_r9_wipe_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (erase && cfg_we) |=> (&and_map[$past(cfg_addr)]) && (&or_map[$past(cfg_addr)]));

    // R7: a load lands on the addressed row
    a_r7_row_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !erase && addr_ok) |=>
            (and_map[$past(cfg_addr)] == $past(cfg_and)) &&
            (or_map[$past(cfg_addr)] == $past(cfg_or)));

    // R10: with no request the array is unchanged
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && !erase) |=> $stable(and_map) && $stable(or_map));

endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
    parameter int N_IN   = 8,
    parameter int N_TERM = 16,
    localparam int LIT_W = 2 * N_IN
) (
    input  logic [N_IN-1:0]               in_vec,
    input  logic [N_TERM-1:0][LIT_W-1:0]  and_map,
    output logic [N_TERM-1:0]             term
);

    logic [LIT_W-1:0] lit;

    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign lit[2*i]   = in_vec[i];
        assign lit[2*i+1] = ~in_vec[i];
    end

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        // a broken link (0) forces its literal to 1
        assign term[t] = &(lit | ~and_map[t]);
    end

endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
    parameter int N_OUT  = 4,
    parameter int N_TERM = 16
) (
    input  logic [N_TERM-1:0]             term,
    input  logic [N_TERM-1:0][N_OUT-1:0]  or_map,
    output logic [N_OUT-1:0]              out_vec
);

    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        logic [N_TERM-1:0] col;
        for (genvar t = 0; t < N_TERM; t++) begin : g_col
            assign col[t] = or_map[t][j];
        end
        assign out_vec[j] = |(term & col);
    end

endmodule

// File: rtl/sop_array.sv
module sop_array #(
    parameter int N_IN   = 8,
    parameter int N_OUT  = 4,
    parameter int N_TERM = 16,
    localparam int LIT_W  = 2 * N_IN,
    localparam int ADDR_W = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [LIT_W-1:0]  cfg_and,
    input  logic [N_OUT-1:0]  cfg_or,
    input  logic [N_IN-1:0]   in_vec,
    output logic [N_OUT-1:0]  out_vec
);

    logic [N_TERM-1:0][LIT_W-1:0] and_map;
    logic [N_TERM-1:0][N_OUT-1:0] or_map;
    logic [N_TERM-1:0]            term;

    sop_link_store #(.N_IN(N_IN), .N_OUT(N_OUT), .N_TERM(N_TERM)) u_store (
        .clk(clk), .rst_n(rst_n), .erase(erase), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_and(cfg_and), .cfg_or(cfg_or),
        .and_map(and_map), .or_map(or_map)
    );

    sop_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
        .in_vec(in_vec), .and_map(and_map), .term(term)
    );

    sop_or_plane #(.N_OUT(N_OUT), .N_TERM(N_TERM)) u_or (
        .term(term), .or_map(or_map), .out_vec(out_vec)
    );

    // R1: leaving reset, the array is erased and every output is low
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> out_vec == '0);

    // R8: after a wipe no output can be high
    a_r8_out_zero: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> out_vec == '0);

endmodule

// File: tb/sop_array_bench.sv
`timescale 1ns/1ps
module sop_array_bench;

    localparam int NI = 8;
    localparam int NO = 4;
    localparam int NT = 16;
    localparam int LW = 2 * NI;
    localparam int AW = $clog2(NT);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          erase = 1'b0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [LW-1:0] cfg_and = '0;
    logic [NO-1:0] cfg_or = '0;
    logic [NI-1:0] in_vec = '0;
    logic [NO-1:0] out_vec;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [LW-1:0] m_and [NT];
    logic [NO-1:0] m_or  [NT];

    always #4 clk = ~clk;

    sop_array #(.N_IN(NI), .N_OUT(NO), .N_TERM(NT)) u_sop_array (
        .clk(clk), .rst_n(rst_n), .erase(erase), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_and(cfg_and), .cfg_or(cfg_or),
        .in_vec(in_vec), .out_vec(out_vec)
    );

    function automatic logic [NO-1:0] model(input logic [NI-1:0] v);
        logic [NO-1:0] acc = '0;
        for (int t = 0; t < NT; t++) begin
            logic hit = 1'b1;
            for (int i = 0; i < NI; i++) begin
                if (m_and[t][2*i]   && !v[i]) hit = 1'b0;
                if (m_and[t][2*i+1] &&  v[i]) hit = 1'b0;
            end
            if (hit) acc |= m_or[t];
        end
        return acc;
    endfunction

    task automatic model_wipe();
        for (int t = 0; t < NT; t++) begin
            m_and[t] = '1;
            m_or[t]  = '1;
        end
    endtask

    task automatic check(input string req, input logic [NO-1:0] exp);
        checks++;
        if (out_vec !== exp) begin
            fails++;
            $display("FAIL %s in=%h actual=%h expected=%h", req, in_vec, out_vec, exp);
        end
    endtask

    // full sweep of all input patterns against the model
    task automatic sweep(input string req);
        for (int v = 0; v < (1 << NI); v++) begin
            in_vec = v[NI-1:0];
            #1;
            check(req, model(in_vec));
        end
    endtask

    task automatic write_row(input int a, input logic [LW-1:0] ad, input logic [NO-1:0] od);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a[AW-1:0]; cfg_and = ad; cfg_or = od;
        @(negedge clk);
        cfg_we = 1'b0;
        m_and[a] = ad;
        m_or[a]  = od;
    endtask

    task automatic pulse_erase();
        @(negedge clk);
        erase = 1'b1;
        @(negedge clk);
        erase = 1'b0;
        model_wipe();
    endtask

    function automatic logic [LW-1:0] rand_and();
        logic [LW-1:0] r = '0;
        for (int i = 0; i < NI; i++) begin
            int c = int'($urandom_range(0, 9));
            if (c < 2)      r[2*i]   = 1'b1;
            else if (c < 4) r[2*i+1] = 1'b1;
            else if (c == 9) begin r[2*i] = 1'b1; r[2*i+1] = 1'b1; end
        end
        return r;
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        model_wipe();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R3: erased array, every term holds both polarities
        sweep("R1_R3_erased");

        // R2, R4, R5, R6: hand-built function
        // term0 = x0 & ~x1 -> out0, out2 ; term1 constant 1 -> out1 only
        begin
            logic [LW-1:0] a0 = '0;
            a0[0] = 1'b1; a0[3] = 1'b1;
            write_row(0, a0, 4'b0101);
        end
        write_row(1, '0, 4'b0010);
        sweep("R2_R4_R5_R6_fixed");
        in_vec = 8'h01; #1; check("R5_shared", 4'b0111);
        in_vec = 8'h03; #1; check("R2_literal", 4'b0010);
        in_vec = 8'hFE; #1; check("R4_R6_const", 4'b0010);

        // R3: term with both literals of x2 intact stays 0
        begin
            logic [LW-1:0] a2 = '0;
            a2[4] = 1'b1; a2[5] = 1'b1;
            write_row(2, a2, 4'b1000);
        end
        sweep("R3_both_literals");

        // R7: random full configurations
        for (int r = 0; r < 5; r++) begin
            for (int t = 0; t < NT; t++) write_row(t, rand_and(), NO'($urandom));
            sweep("R7_R11_random");
        end

        // R7: one row rewritten, neighbours untouched
        write_row(7, '0, 4'b1001);
        sweep("R7_single_row");

        // R10: port data moves with the enable low
        @(negedge clk);
        cfg_addr = 4'd3; cfg_and = '0; cfg_or = '1;
        repeat (2) @(negedge clk);
        sweep("R10_ignored");

        // R8: wipe in one clock
        pulse_erase();
        sweep("R8_wipe");

        // R9: erase and load together
        write_row(3, '0, 4'b1111);
        in_vec = 8'h5A; #1; check("R9_setup", 4'b1111);
        @(negedge clk);
        erase = 1'b1; cfg_we = 1'b1; cfg_addr = 4'd5; cfg_and = '0; cfg_or = 4'b1111;
        @(negedge clk);
        erase = 1'b0; cfg_we = 1'b0;
        model_wipe();
        sweep("R9_wipe_wins");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule